// File: doc/BRIEF.md
# Plug Presence Change Notifier

This block watches a vector of per-port plug-presence flags and tells an audio link controller when the set of connected jacks changes. The flags come from an analog sense front end that is outside this block. Each flag is debounced against a slow free-running tick that keeps running when the link clock is stopped. The result is held in a presence register that software can read. A change is found by comparing the debounced vector with a copy taken at the last notification. Changes that arrive before the next notification merge into a single pending event.

If the link is powered and out of reset, the block issues an unsolicited response at once. The response carries a programmable tag and the lowest index among the enabled ports that changed. If the link is held in reset with its clock stopped, the block first pulses a wake request, and only one wake request is raised until the link leaves reset. After that it holds the response until the controller signals that enumeration is complete. A watchdog times the pending period against a cycle budget that stands for the 10 ms latency limit. While the analog supply is reported bad, the presence values are marked invalid and no notifications are sent.

Top module: `jack_notify`

## Requirements
- R1: After reset, presence is all zero, and unsol_valid, wake_req and timeout_flag are low.
- R2: A presence bit takes the raw sense level only after that level has differed from it on db_ticks consecutive tick samples. A db_ticks value of 0 acts as 1. Presence changes only in the cycle after a tick.
- R3: A raw excursion that lasts fewer tick samples than db_ticks leaves presence unchanged and raises no notification.
- R4: With link_reset low, a change on an enabled port raises unsol_valid for exactly one cycle, one cycle after presence updates. unsol_tag equals resp_tag and unsol_port equals the changed port index.
- R5: A change on a port whose port_en bit is 0 raises no notification. Setting that enable bit later does not produce a notification for the old change.
- R6: Changes that are pending together produce one response, and unsol_port is the lowest changed index.
- R7: With link_reset high and link_clk_run low, a change raises a one-cycle wake_req and no response. No further wake_req is raised until link_reset has gone low.
- R8: After the link leaves reset, a deferred response is issued only on an enum_done pulse, in the cycle after that pulse. One response covers every change merged while the link was down.
- R9: presence_valid follows supply_good. While supply_good is low, no wake_req or unsol_valid is raised, and a pending change is reported once supply_good returns high.
- R10: If a notification stays pending for more than WD_LIMIT clock cycles, timeout_flag goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle debounce sample strobe from a low-power timer |
| sense_raw | input | NPORT | Raw plug-presence flags, bit i for port i |
| db_ticks | input | DB_W | Number of stable tick samples needed to accept a level |
| supply_good | input | 1 | Analog supply present and stable |
| port_en | input | NPORT | Per-port notification enable |
| resp_tag | input | TAG_W | Tag placed in each unsolicited response |
| link_reset | input | 1 | Link held in reset |
| link_clk_run | input | 1 | Link clock running |
| enum_done | input | 1 | One-cycle pulse when device enumeration completes |
| presence | output | NPORT | Debounced presence register |
| presence_valid | output | 1 | Presence register is valid |
| wake_req | output | 1 | One-cycle power state change request |
| unsol_valid | output | 1 | One-cycle unsolicited response strobe |
| unsol_tag | output | TAG_W | Tag of the response |
| unsol_port | output | $clog2(NPORT) | Index of the port that changed |
| timeout_flag | output | 1 | Sticky flag: pending notification exceeded WD_LIMIT cycles |

## Verification
The main function is driven with four kinds of input. A single-port insertion with the link up checks the direct response path and its cycle timing. A simultaneous two-port change checks merging and the lowest-index choice. Two changes that arrive while the link is in low power separate the wake request from the deferred response, and they show that only one wake goes out and that the release waits for enumeration rather than for the end of link reset. Short glitches, a disabled port, a supply drop and an over-long wait then check that debounce, enable masking, supply gating and the watchdog each block or flag what they should and nothing else.

// File: rtl/jack_notify.sv
module jack_notify #(
  parameter int NPORT    = 8,
  parameter int DB_W     = 8,
  parameter int TAG_W    = 6,
  parameter int WD_LIMIT = 240000,
  localparam int PIDX_W  = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int WD_W    = $clog2(WD_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [NPORT-1:0]  sense_raw,
  input  logic [DB_W-1:0]   db_ticks,
  input  logic              supply_good,
  input  logic [NPORT-1:0]  port_en,
  input  logic [TAG_W-1:0]  resp_tag,
  input  logic              link_reset,
  input  logic              link_clk_run,
  input  logic              enum_done,
  output logic [NPORT-1:0]  presence,
  output logic              presence_valid,
  output logic              wake_req,
  output logic              unsol_valid,
  output logic [TAG_W-1:0]  unsol_tag,
  output logic [PIDX_W-1:0] unsol_port,
  output logic              timeout_flag
);

  typedef enum logic [1:0] {S_IDLE, S_LINK, S_ENUM} state_t;

  localparam logic [WD_W-1:0] WD_MAX = WD_W'(WD_LIMIT);

  state_t             state;
  logic [NPORT-1:0]   reported;
  logic [NPORT-1:0]   diff;
  logic [PIDX_W-1:0]  first_idx;
  logic               wake_sent;
  logic [WD_W-1:0]    wd_cnt;
  logic [DB_W-1:0]    thr;
  logic               lowpwr;
  logic               can_send;

  assign thr            = (db_ticks == '0) ? DB_W'(1) : db_ticks;
  assign lowpwr         = link_reset & ~link_clk_run;
  assign diff           = (presence ^ reported) & port_en;
  assign can_send       = supply_good & (|diff);
  assign presence_valid = supply_good;

  for (genvar g = 0; g < NPORT; g++) begin : g_db
    logic [DB_W-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt         <= '0;
        presence[g] <= 1'b0;
      end else if (tick) begin
        if (sense_raw[g] != presence[g]) begin
          if ((DB_W+1)'(cnt) + (DB_W+1)'(1) >= (DB_W+1)'(thr)) begin
            presence[g] <= sense_raw[g];
            cnt         <= '0;
          end else begin
            cnt <= cnt + DB_W'(1);
          end
        end else begin
          cnt <= '0;
        end
      end
    end
  end

  always_comb begin
    first_idx = '0;
    for (int i = NPORT - 1; i >= 0; i--)
      if (diff[i]) first_idx = PIDX_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      reported    <= '0;
      wake_sent   <= 1'b0;
      wake_req    <= 1'b0;
      unsol_valid <= 1'b0;
      unsol_tag   <= '0;
      unsol_port  <= '0;
    end else begin
      wake_req    <= 1'b0;
      unsol_valid <= 1'b0;
      reported    <= (reported & port_en) | (presence & ~port_en);
      case (state)
        S_IDLE: begin
          if (can_send && !unsol_valid) begin
            if (!link_reset) begin
              unsol_valid <= 1'b1;
              unsol_tag   <= resp_tag;
              unsol_port  <= first_idx;
              reported    <= presence;
            end else begin
              state <= S_LINK;
            end
          end
        end
        S_LINK: begin
          if (!link_reset) begin
            state     <= S_ENUM;
            wake_sent <= 1'b0;
          end else if (lowpwr && !wake_sent && supply_good) begin
            wake_req  <= 1'b1;
            wake_sent <= 1'b1;
          end
        end
        S_ENUM: begin
          if (link_reset) begin
            state <= S_LINK;
          end else if (enum_done) begin
            state <= S_IDLE;
            if (can_send) begin
              unsol_valid <= 1'b1;
              unsol_tag   <= resp_tag;
              unsol_port  <= first_idx;
              reported    <= presence;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_cnt       <= '0;
      timeout_flag <= 1'b0;
    end else if (state == S_IDLE) begin
      wd_cnt <= '0;
    end else if (wd_cnt == WD_MAX) begin
      timeout_flag <= 1'b1;
    end else begin
      wd_cnt <= wd_cnt + WD_W'(1);
    end
  end

  assert_presence_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(presence));
  assert_unsol_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    unsol_valid |=> !unsol_valid);
  assert_wake_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req);
  assert_wake_lowpwr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(link_reset && !link_clk_run));
  assert_unsol_link_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unsol_valid |-> !$past(link_reset));
  assert_supply_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (unsol_valid || wake_req) |-> $past(supply_good));
  assert_timeout_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |=> timeout_flag);

endmodule

// File: tb/jack_notify_bench.sv
module jack_notify_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPORT = 8;
  localparam int DB_W = 8;
  localparam int TAG_W = 6;
  localparam int WD_LIMIT = 60;
  localparam int PIDX_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [NPORT-1:0] sense_raw = '0;
  logic [DB_W-1:0] db_ticks = 8'd3;
  logic supply_good = 1'b1;
  logic [NPORT-1:0] port_en = 8'hBF;
  logic [TAG_W-1:0] resp_tag = 6'h2A;
  logic link_reset = 1'b0;
  logic link_clk_run = 1'b1;
  logic enum_done = 1'b0;
  logic [NPORT-1:0] presence;
  logic presence_valid, wake_req, unsol_valid, timeout_flag;
  logic [TAG_W-1:0] unsol_tag;
  logic [PIDX_W-1:0] unsol_port;

  int checks = 0, fails = 0;
  int n_unsol, n_wake, last_port, last_tag;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jack_notify #(.NPORT(NPORT), .DB_W(DB_W), .TAG_W(TAG_W), .WD_LIMIT(WD_LIMIT)) u_jack_notify (
    .clk, .rst_n, .tick, .sense_raw, .db_ticks, .supply_good, .port_en, .resp_tag,
    .link_reset, .link_clk_run, .enum_done, .presence, .presence_valid, .wake_req,
    .unsol_valid, .unsol_tag, .unsol_port, .timeout_flag);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) do_tick();
  endtask

  task automatic observe(int n);
    n_unsol = 0; n_wake = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (unsol_valid) begin n_unsol++; last_port = unsol_port; last_tag = unsol_tag; end
      if (wake_req) n_wake++;
    end
  endtask

  task automatic t_reset();
    check("R1 presence", presence, 0);
    check("R1 unsol", unsol_valid, 0);
    check("R1 wake", wake_req, 0);
    check("R1 timeout", timeout_flag, 0);
  endtask

  task automatic t_direct();
    sense_raw[2] = 1'b1;
    ticks(2);
    check("R2 not yet", presence[2], 0);
    do_tick();
    check("R2 accepted", presence[2], 1);
    check("R4 no pulse yet", unsol_valid, 0);
    @(negedge clk);
    check("R4 pulse", unsol_valid, 1);
    check("R4 port", unsol_port, 2);
    check("R4 tag", unsol_tag, 6'h2A);
    observe(4);
    check("R4 single", n_unsol, 0);
  endtask

  task automatic t_glitch();
    sense_raw[2] = 1'b0;
    ticks(2);
    sense_raw[2] = 1'b1;
    ticks(3);
    check("R3 presence kept", presence[2], 1);
    observe(5);
    check("R3 no response", n_unsol, 0);
  endtask

  task automatic t_dbzero();
    db_ticks = 8'd0;
    sense_raw[3] = 1'b1;
    do_tick();
    check("R2 zero as one", presence[3], 1);
    observe(4);
    check("R2 response", n_unsol, 1);
    check("R2 port", last_port, 3);
    db_ticks = 8'd3;
  endtask

  task automatic t_merge();
    sense_raw[5] = 1'b1; sense_raw[1] = 1'b1;
    ticks(3);
    observe(5);
    check("R6 one response", n_unsol, 1);
    check("R6 lowest index", last_port, 1);
  endtask

  task automatic t_disabled();
    sense_raw[6] = 1'b1;
    ticks(3);
    observe(5);
    check("R5 presence", presence[6], 1);
    check("R5 no response", n_unsol, 0);
    port_en[6] = 1'b1;
    observe(5);
    check("R5 no stale", n_unsol, 0);
  endtask

  task automatic t_lowpower();
    link_reset = 1'b1; link_clk_run = 1'b0;
    sense_raw[0] = 1'b1;
    ticks(3);
    observe(6);
    check("R7 wake", n_wake, 1);
    check("R7 no response", n_unsol, 0);
    sense_raw[4] = 1'b1;
    ticks(3);
    observe(6);
    check("R7 one wake only", n_wake, 0);
    link_reset = 1'b0; link_clk_run = 1'b1;
    observe(5);
    check("R8 held", n_unsol, 0);
    @(negedge clk) enum_done = 1'b1;
    @(negedge clk) enum_done = 1'b0;
    check("R8 released", unsol_valid, 1);
    check("R8 port", unsol_port, 0);
    observe(5);
    check("R8 merged", n_unsol, 0);
    check("R10 within budget", timeout_flag, 0);
  endtask

  task automatic t_supply();
    @(negedge clk) supply_good = 1'b0;
    check("R9 invalid", presence_valid, 0);
    sense_raw[0] = 1'b0;
    ticks(3);
    observe(5);
    check("R9 suppressed", n_unsol, 0);
    supply_good = 1'b1;
    observe(5);
    check("R9 valid", presence_valid, 1);
    check("R9 released", n_unsol, 1);
    check("R9 port", last_port, 0);
  endtask

  task automatic t_watchdog();
    link_reset = 1'b1; link_clk_run = 1'b0;
    sense_raw[4] = 1'b0;
    ticks(3);
    observe(80);
    check("R10 wake", n_wake, 1);
    check("R10 timeout", timeout_flag, 1);
    link_reset = 1'b0; link_clk_run = 1'b1;
    observe(2);
    @(negedge clk) enum_done = 1'b1;
    @(negedge clk) enum_done = 1'b0;
    check("R10 late response", unsol_valid, 1);
    check("R10 port", unsol_port, 4);
    observe(3);
    check("R10 sticky", timeout_flag, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_glitch();
    t_dbzero();
    t_merge();
    t_disabled();
    t_lowpower();
    t_supply();
    t_watchdog();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule